// File: doc/BRIEF.md
# Complement-Toggle Service Watchdog Timer

This block is a watchdog timer with a 16-bit register interface. Its timeout register holds an enable flag and a 15-bit reload count. A prescaler turns the system clock into a single-cycle enable at 500 Hz. Each time that enable pulses while the watchdog runs, a down-counter loses one. If the counter reaches zero while the watchdog is enabled, the block raises a sticky reset request.

Software keeps the system alive by writing to a trigger register. The only value accepted is the bitwise complement of what the register holds now. As a result, accepted service values alternate between 0x5555 and 0xAAAA. Any other write to the trigger register is dropped. A stuck or repeating software loop therefore cannot keep the watchdog quiet by writing the same word again and again.

Top module: `svc_watchdog`

## Requirements
- R1: The timeout register decodes at byte address 0x10, with the enable flag in bit 15 and the reload count in bits 14:0. The trigger register decodes at byte address 0x14. A read of any other address returns 0.
- R2: The stored reload count is never zero. A write of count 0 to the timeout register stores count 1.
- R3: After reset, the timeout register reads 0x7FFF (disabled, maximum count) and the trigger register reads 0x5555.
- R4: A trigger write equal to the bitwise complement of the current trigger value is a valid service. It stores the new value and reloads the counter from the stored count.
- R5: A trigger write of any other value changes neither the trigger register nor the counter.
- R6: Every write to the timeout register reloads the counter from the newly written count. This includes a write that sets the enable flag.
- R7: While enabled, the counter decrements by one on each prescaler tick. A tick occurs once every CLK_HZ/TICK_HZ clocks, with the first tick falling on the last clock of the first prescaler period after reset.
- R8: `wdg_rst` rises on the clock after the one in which the counter is zero while enabled and no reload occurs. It then stays high until `rst_n` is asserted.
- R9: While the enable flag is clear, the counter holds its value and `wdg_rst` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per clock |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | ADDR_W | Byte address of the combinational read |
| rd_data | output | 16 | Read data |
| wdg_rst | output | 1 | Sticky reset request on expiry |

## Verification
Register contents follow a write on the next clock, and `rd_data` reflects `rd_addr` combinationally. The bench therefore reads back one clock after each write, shortly after the falling edge.

A reload, or a decrement on a tick, takes effect at the same edge that samples the write or the tick. `wdg_rst` follows the zero state one edge later. The bench compares `wdg_rst` against its own model at every falling edge, so an expiry that arrives one cycle early or one cycle late is caught.

The model counts prescaler phases from reset on its own. Its expiry cycle is therefore derived from the tick period rather than taken from the design.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam int unsigned REG_W      = 16;
   localparam logic [7:0]  OFS_TMO    = 8'h10;
   localparam logic [7:0]  OFS_TRIG   = 8'h14;
   localparam logic [15:0] TRIG_INIT  = 16'h5555;
   localparam logic [15:0] TMO_INIT   = 16'h7FFF;

   typedef struct packed {
      logic        run;
      logic [14:0] cnt;
   } tmo_reg_t;
endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
   parameter int unsigned DIV = 100000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV <= 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase_q <= '0;
            else if (phase_q == LAST)
               phase_q <= '0;
            else
               phase_q <= phase_q + 1'b1;
         end

         assign tick = (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdg_regfile.sv
module wdg_regfile
   import wdg_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CNT_W  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic              en,
   output logic [CNT_W-1:0]  tmo_cnt,
   output logic [REG_W-1:0]  trig,
   output logic              reload,
   output logic [CNT_W-1:0]  load_val
);
   localparam logic [ADDR_W-1:0] A_TMO  = ADDR_W'(OFS_TMO);
   localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);

   tmo_reg_t        tmo_q;
   logic [REG_W-1:0] trig_q;
   logic            hit_tmo, hit_trig, kick;
   logic [CNT_W-1:0] wr_cnt;

   assign hit_tmo  = wr_en && (wr_addr == A_TMO);
   assign hit_trig = wr_en && (wr_addr == A_TRIG);
   assign kick     = hit_trig && (wr_data == ~trig_q);
   assign wr_cnt   = (wr_data[CNT_W-1:0] == '0) ? CNT_W'(1) : wr_data[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_q  <= tmo_reg_t'(TMO_INIT);
         trig_q <= TRIG_INIT;
      end else begin
         if (hit_tmo) begin
            tmo_q.run <= wr_data[REG_W-1];
            tmo_q.cnt <= wr_cnt;
         end
         if (kick)
            trig_q <= wr_data;
      end
   end

   assign reload   = hit_tmo || kick;
   assign load_val = hit_tmo ? wr_cnt : tmo_q.cnt;
   assign en       = tmo_q.run;
   assign tmo_cnt  = tmo_q.cnt;
   assign trig     = trig_q;

   always_comb begin
      if (rd_addr == A_TMO)
         rd_data = tmo_q;
      else if (rd_addr == A_TRIG)
         rd_data = trig_q;
      else
         rd_data = '0;
   end
endmodule

// File: rtl/wdg_down_cnt.sv
module wdg_down_cnt #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             reload,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;
   logic             exp_q;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '1;
         exp_q <= 1'b0;
      end else begin
         if (reload)
            cnt_q <= load_val;
         else if (en && tick && !at_zero)
            cnt_q <= cnt_q - 1'b1;
         if (en && at_zero && !reload)
            exp_q <= 1'b1;
      end
   end

   assign cnt     = cnt_q;
   assign expired = exp_q;
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
   import wdg_pkg::*;
#(
   parameter int unsigned CLK_HZ  = 50000000,
   parameter int unsigned TICK_HZ = 500,
   parameter int unsigned ADDR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [15:0]       rd_data,
   output logic              wdg_rst
);
   localparam int unsigned CNT_W = REG_W - 1;
   localparam int unsigned DIV   = CLK_HZ / TICK_HZ;

   generate
      if (TICK_HZ == 0 || CLK_HZ < TICK_HZ) begin : g_bad_rate
         $error("svc_watchdog: CLK_HZ must be at least TICK_HZ and TICK_HZ nonzero");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("svc_watchdog: ADDR_W too narrow for the register offsets");
      end
   endgenerate

   logic             tick, en, reload;
   logic [CNT_W-1:0] tmo_cnt, load_val, cnt;
   logic [15:0]      trig;

   wdg_tick_gen #(.DIV(DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   wdg_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .en(en), .tmo_cnt(tmo_cnt), .trig(trig), .reload(reload),
      .load_val(load_val)
   );

   wdg_down_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .reload(reload),
      .load_val(load_val), .cnt(cnt), .expired(wdg_rst)
   );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
   parameter int unsigned CNT_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             en,
   input logic             reload,
   input logic [CNT_W-1:0] load_val,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] tmo_cnt,
   input logic [15:0]      trig,
   input logic             wdg_rst
);
   p_sticky_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wdg_rst |=> wdg_rst);

   p_no_rst_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !wdg_rst) |=> !wdg_rst);

   p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !reload) |=> $stable(cnt));

   p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && !tick) |=> $stable(cnt));

   p_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && en && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (cnt == $past(load_val)));

   p_cnt_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_cnt != '0);

   p_trig_pattern_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trig == 16'h5555) || (trig == 16'hAAAA));
endmodule

bind svc_watchdog wdg_checker #(.CNT_W(CNT_W)) u_wdg_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .reload(reload),
   .load_val(load_val), .cnt(cnt), .tmo_cnt(tmo_cnt), .trig(trig),
   .wdg_rst(wdg_rst)
);

// File: tb/test_svc_watchdog.sv
`timescale 1ns/1ps
module test_svc_watchdog;
   localparam int CLK_HZ  = 5000;
   localparam int TICK_HZ = 500;
   localparam int DIV     = CLK_HZ / TICK_HZ;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        wdg_rst;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit started = 0;
   bit done = 0;

   // behavioural model state
   int m_pc, m_cnt, m_tcnt, m_trig;
   bit m_en, m_rst;

   always #10 clk = ~clk;

   svc_watchdog #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .ADDR_W(8)) i_svc_watchdog (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .wdg_rst(wdg_rst)
   );

   always @(posedge clk) begin
      bit tk, rl, fire;
      int lv;
      cycles++;
      if (!rst_n) begin
         m_pc = 0; m_cnt = 32'h7FFF; m_tcnt = 32'h7FFF; m_en = 0;
         m_trig = 32'h5555; m_rst = 0;
      end else begin
         tk = (m_pc == DIV - 1);
         m_pc = tk ? 0 : m_pc + 1;
         rl = 0; lv = 0;
         fire = m_en && (m_cnt == 0);
         if (wr_en && wr_addr == 8'h10) begin
            rl = 1;
            lv = (wr_data[14:0] == 0) ? 1 : int'(wr_data[14:0]);
         end else if (wr_en && wr_addr == 8'h14 && int'(wr_data) == (m_trig ^ 32'hFFFF)) begin
            rl = 1; lv = m_tcnt; m_trig = int'(wr_data);
         end
         if (fire && !rl) m_rst = 1;
         if (rl) m_cnt = lv;
         else if (m_en && tk && m_cnt != 0) m_cnt = m_cnt - 1;
         if (wr_en && wr_addr == 8'h10) begin
            m_en = wr_data[15];
            m_tcnt = lv;
         end
      end
      started = 1;
   end

   // per-cycle comparison of the reset request (R8, R9)
   always @(negedge clk) begin
      if (started && !done) begin
         checks++;
         if (wdg_rst !== m_rst) begin
            errors++;
            $display("FAIL R8/R9 cycle %0d: wdg_rst=%0b expected %0b", cycles, wdg_rst, m_rst);
         end
      end
   end

   initial begin
      wait (cycles > 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [15:0] exp, input string req);
      rd_addr = a;
      #1;
      checks++;
      if (rd_data !== exp) begin
         errors++;
         $display("FAIL %s read 0x%02h: actual 0x%04h expected 0x%04h", req, a, rd_data, exp);
      end
   endtask

   task automatic bit_chk(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   initial begin
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 reset values, R1 decode
      rd_chk(8'h10, 16'h7FFF, "R3");
      rd_chk(8'h14, 16'h5555, "R3");
      rd_chk(8'h18, 16'h0000, "R1");
      rd_chk(8'h00, 16'h0000, "R1");
      // R2 zero count clamps to one
      wr(8'h10, 16'h0000);
      rd_chk(8'h10, 16'h0001, "R2");
      wr(8'h10, 16'h8000);
      rd_chk(8'h10, 16'h8001, "R2");
      // R9 disabled with short count: no expiry
      wr(8'h10, 16'h0003);
      rd_chk(8'h10, 16'h0003, "R1");
      idle(100);
      bit_chk(wdg_rst, 1'b0, "R9 disabled no reset");
      // R6 enable with count 5, R4 valid kicks keep it alive
      wr(8'h10, 16'h8005);
      for (int k = 0; k < 4; k++) begin
         idle(30);
         wr(8'h14, (k % 2 == 0) ? 16'hAAAA : 16'h5555);
         rd_chk(8'h14, (k % 2 == 0) ? 16'hAAAA : 16'h5555, "R4");
      end
      // R5 invalid trigger writes ignored
      wr(8'h14, 16'h5555);
      rd_chk(8'h14, 16'h5555, "R5");
      wr(8'h14, 16'h1234);
      rd_chk(8'h14, 16'h5555, "R5");
      bit_chk(wdg_rst, 1'b0, "R4 alive after kicks");
      // R6 timeout rewrites keep it alive
      for (int k = 0; k < 5; k++) begin
         idle(25);
         wr(8'h10, 16'h8004);
      end
      bit_chk(wdg_rst, 1'b0, "R6 alive after rewrites");
      // R9 disable and wait long
      wr(8'h10, 16'h0005);
      idle(200);
      bit_chk(wdg_rst, 1'b0, "R9 held off");
      // R7/R8 expiry: count 3 => zero after at most 4 ticks
      wr(8'h10, 16'h8003);
      idle(60);
      bit_chk(wdg_rst, 1'b1, "R8 expiry");
      // R8 sticky despite disable and valid kick
      wr(8'h10, 16'h0005);
      wr(8'h14, 16'hAAAA);
      idle(50);
      bit_chk(wdg_rst, 1'b1, "R8 sticky");
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      bit_chk(wdg_rst, 1'b0, "R8 cleared by reset");
      rd_chk(8'h14, 16'h5555, "R3");
      // R5 invalid writes do not reload: expiry follows original schedule
      wr(8'h10, 16'h8002);
      for (int k = 0; k < 8; k++) begin
         idle(3);
         wr(8'h14, 16'h5555);
      end
      idle(20);
      bit_chk(wdg_rst, 1'b1, "R5 no reload from bad kick");
      // R7 count 1, single tick to expiry
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      wr(8'h10, 16'h8001);
      idle(2 * DIV + 4);
      bit_chk(wdg_rst, 1'b1, "R7 one tick expiry");
      idle(5);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule